// File: doc/BRIEF.md
# Double-Buffered Feedforward Waveform Player

The player holds two setpoint tables. Each table has 2^TBL_AW words, which is 1024 by default. A host writes the tables on its own clock. A host-side address counter is cleared by a start strobe and then moves up one place for each word the host marks as valid. A write-bank select chooses which table receives the words. On the logic clock, a read-bank select chooses which table is played. The two selects do not depend on each other, so the host can refill one table while the other one is playing.

A rising edge on the trigger input starts a sweep. The sweep steps a sample address of TBL_AW+1 bits from zero to its last value and then stops. It moves one step every 2^zoom clock cycles. Every stored pair of words becomes four samples: the first word, the second word, the negated first word and the negated second word. The table index is the sample address with bit 1 removed. Bit 1 selects the negation. The two low address bits are reported as a quadrant code. A strobe marks each new sample. A busy flag and a one-cycle done pulse frame the sweep.

Top module: `ffwave_player`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `busy`, `done` and `strobe` are low, and `dout` and `samp_addr` are zero.
- R2: A rising edge of `go` seen on a clock edge while idle starts a sweep. `busy` is high after that edge, and the first `strobe` (sample address 0) is seen two clock edges later. Holding `go` high does not start another sweep.
- R3: A rising edge of `go` while `busy` is high has no effect. This includes the edge on which the sweep ends. The address sequence continues, and `busy` stays low after the sweep ends.
- R4: Successive strobes of one sweep are exactly 2^`zoom` clock cycles apart, with `zoom` taken as an unsigned integer.
- R5: A sweep outputs 2^(TBL_AW+1) strobes with sample addresses 0, 1, 2, … in order. `done` is high for one cycle, exactly 2^(TBL_AW+1) × 2^`zoom` edges after the starting edge. `busy` falls on the same edge.
- R6: The sample with address a reads table word {a[TBL_AW:2], a[0]}, and `quad` equals a[1:0]. The codes are 0 = I, 1 = Q, 2 = −I, 3 = −Q.
- R7: When a[1] is 0, `dout` is the stored word. When a[1] is 1, `dout` is its two's-complement negation.
- R8: Negating the most negative code gives the most positive code. It does not wrap.
- R9: `wr_init` clears the host address counter. Each `hclk` cycle with `wr_valid` high writes `wr_data` at the counter and advances the counter, and the counter wraps after the last word.
- R10: Host writes go only to the table that `wr_sel` names (0 or 1). Playback reads only the table that `rd_sel` names, so a write to one table does not change what the other table plays.
- R11: When `wr_init` and `wr_valid` are high in the same `hclk` cycle, the word is written at index 0 and the next word goes to index 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Playback clock |
| rst | input | 1 | Synchronous active-high reset, playback side |
| go | input | 1 | Sweep trigger, rising-edge sensitive |
| zoom | input | ZW | Sample interval exponent; interval = 2^zoom cycles |
| rd_sel | input | 1 | Table that is played |
| busy | output | 1 | High while a sweep runs |
| done | output | 1 | One-cycle pulse at sweep end |
| strobe | output | 1 | New sample valid on `dout` |
| samp_addr | output | TBL_AW+1 | Address of the sample on `dout` |
| quad | output | 2 | Quadrant code of the current sample |
| dout | output | DW | Signed setpoint sample |
| hclk | input | 1 | Host write clock |
| wr_sel | input | 1 | Table that host writes target |
| wr_init | input | 1 | Clears the host write address counter |
| wr_valid | input | 1 | Host word valid; write and advance |
| wr_data | input | DW | Host word |

## Verification
A new rising edge on the trigger can arrive on the same clock edge that ends a sweep. The sweep-end logic and the start logic then both want to act on that edge. The bench drops `go` after the start and raises it again so that it is sampled exactly on edge 2^(TBL_AW+1)·2^zoom after the start. It then checks that `done` pulses once and that `busy` stays low for the following cycles. A second case raises `go` in the middle of a sweep, and the bench checks that the address sequence and the strobe spacing are not disturbed. On the host side, `wr_init` and `wr_valid` are raised together, and the played samples show where that word landed.

// File: rtl/ffw_pkg.sv
package ffw_pkg;

    // Default configuration of the player
    localparam int DW_DEF     = 16;
    localparam int TBL_AW_DEF = 10;
    localparam int IW_DEF     = 32;
    localparam int ZW_DEF     = 5;

    // Position of a sample inside the four-step rotation
    typedef enum logic [1:0] {
        Q_I  = 2'd0,
        Q_Q  = 2'd1,
        Q_NI = 2'd2,
        Q_NQ = 2'd3
    } quad_e;

    typedef enum logic {
        SW_IDLE = 1'b0,
        SW_RUN  = 1'b1
    } sweep_e;

    // Second half of the rotation carries inverted samples
    function automatic logic quad_is_negated(input quad_e q);
        return (q == Q_NI) || (q == Q_NQ);
    endfunction

endpackage

// File: rtl/ffw_host_wr.sv
module ffw_host_wr #(
    parameter int AW = 10
) (
    input  logic          hclk,
    input  logic          wr_init,
    input  logic          wr_valid,
    output logic          we,
    output logic [AW-1:0] waddr
);
    logic [AW-1:0] cnt_q;

    // A start strobe forces this cycle's word to index 0
    always_comb begin
        we    = wr_valid;
        waddr = wr_init ? '0 : cnt_q;
    end

    always_ff @(posedge hclk) begin
        if (wr_init) begin
            cnt_q <= wr_valid ? AW'(1) : '0;
        end else if (wr_valid) begin
            cnt_q <= cnt_q + AW'(1);
        end
    end
endmodule

// File: rtl/ffw_table_ram.sv
module ffw_table_ram #(
    parameter int AW    = 10,
    parameter int DW    = 16,
    parameter int NBANK = 2
) (
    input  logic                     hclk,
    input  logic                     we,
    input  logic [$clog2(NBANK)-1:0] wbank,
    input  logic [AW-1:0]            waddr,
    input  logic [DW-1:0]            wdata,
    input  logic                     clk,
    input  logic [$clog2(NBANK)-1:0] rbank,
    input  logic [AW-1:0]            raddr,
    output logic [DW-1:0]            rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic [DW-1:0] mem [DEPTH];

        always_ff @(posedge hclk) begin
            if (we && (wbank == ($clog2(NBANK))'(b))) begin
                mem[waddr] <= wdata;
            end
        end

        assign bank_rd[b] = mem[raddr];
    end

    always_ff @(posedge clk) begin
        rdata <= bank_rd[rbank];
    end
endmodule

// File: rtl/ffw_sweep_ctrl.sv
module ffw_sweep_ctrl
    import ffw_pkg::*;
#(
    parameter int SAW = 11,
    parameter int IW  = 32,
    parameter int ZW  = 5
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           go,
    input  logic [ZW-1:0]  zoom,
    output logic           busy,
    output logic           done,
    output logic           load,
    output logic [SAW-1:0] addr
);
    localparam logic [IW-1:0]  ONE  = IW'(1);
    localparam logic [SAW-1:0] AMAX = '1;

    sweep_e        state_q;
    logic          go_q;
    logic          go_rise;
    logic [IW-1:0] timer_q;
    logic [IW-1:0] tmax;

    always_comb begin
        go_rise = go & ~go_q;
        tmax    = (ONE << zoom) - ONE;
        busy    = (state_q == SW_RUN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            go_q    <= 1'b0;
            timer_q <= '0;
            addr    <= '0;
            done    <= 1'b0;
            load    <= 1'b0;
        end else begin
            go_q <= go;
            done <= 1'b0;
            load <= 1'b0;
            case (state_q)
                SW_IDLE: begin
                    if (go_rise) begin
                        state_q <= SW_RUN;
                        addr    <= '0;
                        timer_q <= '0;
                        load    <= 1'b1;
                    end
                end
                SW_RUN: begin
                    if (timer_q >= tmax) begin
                        timer_q <= '0;
                        if (addr == AMAX) begin
                            state_q <= SW_IDLE;
                            done    <= 1'b1;
                        end else begin
                            addr <= addr + SAW'(1);
                            load <= 1'b1;
                        end
                    end else begin
                        timer_q <= timer_q + ONE;
                    end
                end
                default: state_q <= SW_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ffw_out_stage.sv
module ffw_out_stage
    import ffw_pkg::*;
#(
    parameter int DW  = 16,
    parameter int SAW = 11
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [SAW-1:0] addr,
    input  logic [DW-1:0]  rdata,
    output logic           strobe,
    output logic [SAW-1:0] samp_addr,
    output logic [1:0]     quad,
    output logic [DW-1:0]  dout
);
    localparam logic [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};
    localparam logic [DW-1:0] MAX_CODE = {1'b0, {(DW-1){1'b1}}};

    typedef struct packed {
        logic           valid;
        logic [SAW-1:0] addr;
    } stage_t;

    stage_t        s1_q;
    quad_e         q1;
    logic [DW-1:0] neg_word;
    logic [DW-1:0] next_out;

    always_comb begin
        q1       = quad_e'(s1_q.addr[1:0]);
        neg_word = (rdata == MIN_CODE) ? MAX_CODE : (~rdata + DW'(1));
        next_out = quad_is_negated(q1) ? neg_word : rdata;
    end

    // Stage 1 lines up with the registered table read
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q      <= '0;
            strobe    <= 1'b0;
            samp_addr <= '0;
            quad      <= 2'd0;
            dout      <= '0;
        end else begin
            s1_q.valid <= load;
            s1_q.addr  <= addr;
            strobe     <= s1_q.valid;
            samp_addr  <= s1_q.addr;
            quad       <= s1_q.addr[1:0];
            if (s1_q.valid) begin
                dout <= next_out;
            end
        end
    end
endmodule

// File: rtl/ffwave_player.sv
module ffwave_player
    import ffw_pkg::*;
#(
    parameter int DW     = DW_DEF,
    parameter int TBL_AW = TBL_AW_DEF,
    parameter int IW     = IW_DEF,
    parameter int ZW     = ZW_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [ZW-1:0]     zoom,
    input  logic              rd_sel,
    output logic              busy,
    output logic              done,
    output logic              strobe,
    output logic [TBL_AW:0]   samp_addr,
    output logic [1:0]        quad,
    output logic [DW-1:0]     dout,
    input  logic              hclk,
    input  logic              wr_sel,
    input  logic              wr_init,
    input  logic              wr_valid,
    input  logic [DW-1:0]     wr_data
);
    localparam int SAW = TBL_AW + 1;

    logic              we;
    logic [TBL_AW-1:0] waddr;
    logic              load;
    logic [SAW-1:0]    sweep_addr;
    logic [TBL_AW-1:0] tbl_idx;
    logic [DW-1:0]     rdata;

    // Bit 1 of the sample address picks the sign, not the word
    assign tbl_idx = {sweep_addr[SAW-1:2], sweep_addr[0]};

    ffw_host_wr #(.AW(TBL_AW)) u_host (
        .hclk     (hclk),
        .wr_init  (wr_init),
        .wr_valid (wr_valid),
        .we       (we),
        .waddr    (waddr)
    );

    ffw_table_ram #(.AW(TBL_AW), .DW(DW), .NBANK(2)) u_ram (
        .hclk  (hclk),
        .we    (we),
        .wbank (wr_sel),
        .waddr (waddr),
        .wdata (wr_data),
        .clk   (clk),
        .rbank (rd_sel),
        .raddr (tbl_idx),
        .rdata (rdata)
    );

    ffw_sweep_ctrl #(.SAW(SAW), .IW(IW), .ZW(ZW)) u_sweep (
        .clk  (clk),
        .rst  (rst),
        .go   (go),
        .zoom (zoom),
        .busy (busy),
        .done (done),
        .load (load),
        .addr (sweep_addr)
    );

    ffw_out_stage #(.DW(DW), .SAW(SAW)) u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .addr      (sweep_addr),
        .rdata     (rdata),
        .strobe    (strobe),
        .samp_addr (samp_addr),
        .quad      (quad),
        .dout      (dout)
    );
endmodule

// File: rtl/ffw_checker.sv
module ffw_checker #(
    parameter int DW  = 16,
    parameter int SAW = 11
) (
    input logic           clk,
    input logic           rst,
    input logic           busy,
    input logic           done,
    input logic           strobe,
    input logic [1:0]     quad,
    input logic [DW-1:0]  dout,
    input logic [SAW-1:0] sweep_addr
);
    localparam logic [DW-1:0] MIN_CODE = {1'b1, {(DW-1){1'b0}}};

    p_done_single_r5: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_start_at_zero_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (sweep_addr == '0));

    p_no_restart_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            ((sweep_addr == $past(sweep_addr)) || (sweep_addr == $past(sweep_addr) + SAW'(1))));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && !$past(busy)) |-> $stable(sweep_addr));

    p_no_min_negated_r8: assert property (@(posedge clk) disable iff (rst)
        (strobe && quad[1]) |-> (dout != MIN_CODE));
endmodule

bind ffwave_player ffw_checker #(.DW(DW), .SAW(TBL_AW + 1)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .done       (done),
    .strobe     (strobe),
    .quad       (quad),
    .dout       (dout),
    .sweep_addr (sweep_addr)
);

// File: tb/test_ffwave_player.sv
module test_ffwave_player;
    localparam int DW     = 8;
    localparam int TBL_AW = 3;
    localparam int IW     = 8;
    localparam int ZW     = 3;
    localparam int NW     = 1 << TBL_AW;
    localparam int NS     = 1 << (TBL_AW + 1);

    logic              clk = 1'b0;
    logic              hclk = 1'b0;
    logic              rst = 1'b1;
    logic              go = 1'b0;
    logic [ZW-1:0]     zoom = '0;
    logic              rd_sel = 1'b0;
    logic              busy, done, strobe;
    logic [TBL_AW:0]   samp_addr;
    logic [1:0]        quad;
    logic [DW-1:0]     dout;
    logic              wr_sel = 1'b0;
    logic              wr_init = 1'b0;
    logic              wr_valid = 1'b0;
    logic [DW-1:0]     wr_data = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int mptr = 0;
    logic [DW-1:0] exp_mem [2][NW];

    always #2.5 clk = ~clk;
    always #3.5 hclk = ~hclk;

    ffwave_player #(.DW(DW), .TBL_AW(TBL_AW), .IW(IW), .ZW(ZW)) i_ffwave_player (
        .clk(clk), .rst(rst), .go(go), .zoom(zoom), .rd_sel(rd_sel),
        .busy(busy), .done(done), .strobe(strobe), .samp_addr(samp_addr),
        .quad(quad), .dout(dout), .hclk(hclk), .wr_sel(wr_sel),
        .wr_init(wr_init), .wr_valid(wr_valid), .wr_data(wr_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int b, input int i, input int seed);
        return DW'(b * 100 + i * 29 + seed * 13 - 128);
    endfunction

    function automatic logic [DW-1:0] expect_sample(input int b, input int a);
        logic [DW-1:0] w;
        int idx;
        idx = ((a >> 2) << 1) | (a & 1);
        w = exp_mem[b][idx];
        if ((a & 2) != 0) begin
            if (w == 8'h80) return 8'h7F;
            return DW'(-int'($signed(w)));
        end
        return w;
    endfunction

    // Host writes; model counter follows R9/R11
    task automatic host_block(input int b, input int seed, input int n,
                              input bit with_init, input bit overlap);
        @(negedge hclk);
        wr_sel = b[0];
        if (with_init && !overlap) begin
            wr_init = 1'b1;
            mptr = 0;
            @(negedge hclk);
            wr_init = 1'b0;
        end
        for (int i = 0; i < n; i++) begin
            if (with_init && overlap && i == 0) begin
                wr_init = 1'b1;
                mptr = 0;
            end
            wr_valid = 1'b1;
            wr_data = word_of(b, i, seed);
            exp_mem[b][mptr] = word_of(b, i, seed);
            mptr = (mptr + 1) % NW;
            @(negedge hclk);
            wr_init = 1'b0;
        end
        wr_valid = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic sweep(input int z, input int b, input bit mid_go, input bit end_go);
        int k, nstr, last_k, ndone, done_k, total;
        total = NS << z;
        nstr = 0; last_k = 0; ndone = 0; done_k = -100;
        @(negedge clk);
        rd_sel = b[0];
        zoom = ZW'(z);
        go = 1'b1;
        @(negedge clk);
        k = 0;
        check(busy == 1'b1, "R2 busy after go edge", int'(busy), 1);
        if (mid_go || end_go) go = 1'b0;
        while (k <= done_k + 3 || (ndone == 0 && k < total + 10)) begin
            if (strobe) begin
                if (nstr == 0) check(k == 2, "R2 first strobe latency", k, 2);
                else check(k - last_k == (1 << z), "R4 strobe interval", k - last_k, 1 << z);
                check(int'(samp_addr) == nstr, "R5 address order", int'(samp_addr), nstr);
                check(int'(quad) == (nstr & 3), "R6 quadrant code", int'(quad), nstr & 3);
                check(dout == expect_sample(b, nstr), "R7 R8 R10 sample value",
                      int'($signed(dout)), int'($signed(expect_sample(b, nstr))));
                last_k = k;
                nstr++;
            end
            if (done) begin
                ndone++;
                done_k = k;
                check(k == total, "R5 done timing", k, total);
                check(busy == 1'b0, "R5 busy falls with done", int'(busy), 0);
            end
            if (mid_go && k == 20) go = 1'b1;
            if (mid_go && k == 21) go = 1'b0;
            if (end_go && k == total - 1) go = 1'b1;
            @(negedge clk);
            k++;
        end
        check(nstr == NS, "R5 strobe count", nstr, NS);
        check(ndone == 1, "R5 done pulse count", ndone, 1);
        for (int i = 0; i < 8; i++) begin
            check(busy == 1'b0, end_go ? "R3 edge at sweep end ignored" : "R2 level does not restart",
                  int'(busy), 0);
            @(negedge clk);
        end
        go = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && strobe == 1'b0, "R1 flags in reset",
              int'({busy, done, strobe}), 0);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && strobe == 1'b0, "R1 flags after reset",
              int'({busy, done, strobe}), 0);
        check(dout == '0 && samp_addr == '0, "R1 data after reset",
              int'(dout) + int'(samp_addr), 0);

        host_block(0, 0, NW, 1'b1, 1'b0);      // R9 plain load
        host_block(1, 1, NW, 1'b1, 1'b1);      // R11 init with first word
        host_block(1, 5, 1, 1'b0, 1'b0);       // R9 wrap to index 0

        sweep(0, 0, 1'b0, 1'b0);
        sweep(1, 1, 1'b0, 1'b0);
        sweep(2, 0, 1'b1, 1'b0);               // R3 mid-sweep edge
        sweep(3, 1, 1'b0, 1'b1);               // R3 edge on final cycle
        host_block(0, 3, NW, 1'b1, 1'b0);      // R10 rewrite other table
        sweep(0, 1, 1'b0, 1'b0);
        sweep(7, 0, 1'b0, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule